// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Registers

This block is the register file of a 24-input interrupt router. Software reaches it through two directly addressed 32-bit locations. The first is an index register that picks an internal register. The second is a data window that reads or writes the register the index points at. Behind the window sit an identifier register, a read-only version word, a mirror of the identifier, and one 64-bit redirection entry per input. Each entry is reached as two 32-bit halves.

The block stores the table and drives the per-input fields that the neighbouring trigger logic needs: mask, trigger mode, polarity and in-service (remote-IRR) status. The trigger logic sets an input's in-service bit through a strobe. A write to the low half of an entry clears that bit. Every table write is followed by a one-cycle service request for the written input if that input is pending at the time of the write, so the trigger logic can re-evaluate it.

Top module: `irq_redir_regs`

## Requirements
- R1: A write at byte offset 0x00 stores bits 7:0 of the write data as the window index, and a read there returns that index zero-extended. Accesses at offsets other than 0x00 and 0x10 read as zero and change nothing.
- R2: Read data appears on `busRdata` in the cycle after the read access. In any cycle after a cycle with no read access, `busRdata` is zero.
- R3: Window index 0x01 reads 0x0017_0011: the input count minus one in bits 23:16 and version 0x11 in bits 7:0. Writes to it change nothing.
- R4: Window index 0x00 holds a 4-bit identifier, written from and read in bits 27:24, with all other bits read as zero. Index 0x02 returns the same value and ignores writes.
- R5: Entry n is reached at window index 0x10+2n for its low half and at 0x11+2n for its high half. The low half keeps vector (7:0), delivery mode (10:8), destination mode (11), delivery status (12), polarity (13), remote-IRR (14), trigger mode (15, 1 = level) and mask (16). The high half keeps the destination in bits 31:24 (entry bits 63:56). All other bits read as zero.
- R6: A write to an entry's low half forces its remote-IRR bit to 0, whatever the data bit 14 holds. A write to the high half leaves remote-IRR unchanged.
- R7: A pulse on `remoteIrrSet[n]` sets remote-IRR of entry n. When a low-half write to the same entry happens in the same cycle, the write wins and the bit ends at 0.
- R8: Window indices 0x03 to 0x0F and from 0x40 upward read as zero, and writes to them are discarded.
- R9: In the cycle after a write to either half of entry n, `svcReq` is 1 and `svcIdx` equals n if `pendVec[n]` was 1 during the write cycle. In all other cycles `svcReq` is 0.
- R10: After reset the index and identifier are zero, every entry has its mask bit set, and every other entry field is zero.
- R11: `entMask`, `entLevel`, `entPolarity` and `entRemoteIrr` show bit n equal to the mask, trigger-mode, polarity and remote-IRR fields of entry n as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe for this cycle |
| busWrite | input | 1 | 1 = write access, 0 = read access |
| busAddr | input | 8 | Byte offset inside the block |
| busWdata | input | 32 | Write data (full word) |
| busRdata | output | 32 | Read data, one cycle after the access |
| pendVec | input | 24 | Pending state per input from the trigger logic |
| remoteIrrSet | input | 24 | Per-input strobe that sets remote-IRR |
| svcReq | output | 1 | One-cycle service request after a table write |
| svcIdx | output | 5 | Input the service request refers to |
| entMask | output | 24 | Mask field of each entry |
| entLevel | output | 24 | Trigger-mode field of each entry (1 = level) |
| entPolarity | output | 24 | Polarity field of each entry |
| entRemoteIrr | output | 24 | Remote-IRR field of each entry |

## Verification
The assertions check several properties on every cycle. A low-half write always leaves remote-IRR at 0 in the next cycle. A table write to a pending input always produces the matching service request, and no request appears without a write. Mask bits move only on low-half writes. The read bus is zero after a cycle without a read. Only the bench's scenarios can show the other behaviours: the full register layout and its reserved zeros, the version and identifier contents, the discarding of out-of-range indices, and the write-over-set priority. The bench compares read-backs and the decoded field vectors against its own model after long random sequences.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int NUM_INPUTS = 24;
  localparam int IDX_W      = $clog2(NUM_INPUTS);
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int SEL_W      = 8;
  localparam int ID_W       = 4;
  localparam logic [7:0] VERSION_ID = 8'h11;
  localparam logic [ADDR_W-1:0] OFF_SEL = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_WIN = 8'h10;
  localparam int ENTRY_BASE = 16;
  localparam int TABLE_END  = ENTRY_BASE + 2 * NUM_INPUTS;

  typedef enum logic [2:0] {
    RK_ZERO, RK_SEL, RK_ID, RK_VER, RK_LO, RK_HI
  } rdKind_e;

  typedef struct packed {
    logic             wrId;
    logic             wrLo;
    logic             wrHi;
    logic             rdEn;
    rdKind_e          rdKind;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;
endpackage

// File: rtl/irq_redir_ctl.sv
module irq_redir_ctl
  import irq_redir_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [SEL_W-1:0]  selReg,
  output regStrobe_t        strb
);
  logic             winHit;
  logic             inTable;
  logic [SEL_W-1:0] selOffs;

  always_ff @(posedge clk) begin
    if (!rstN) selReg <= '0;
    else if (busSel && busWrite && busAddr == OFF_SEL) selReg <= busWdata[SEL_W-1:0];
  end

  always_comb begin
    winHit  = busSel && (busAddr == OFF_WIN);
    inTable = (int'(selReg) >= ENTRY_BASE) && (int'(selReg) < TABLE_END);
    selOffs = selReg - SEL_W'(ENTRY_BASE);
    strb = '0;
    strb.idx  = selOffs[IDX_W:1];
    strb.rdEn = busSel && !busWrite;
    if (busAddr == OFF_SEL) strb.rdKind = RK_SEL;
    else if (busAddr == OFF_WIN) begin
      if (selReg == 8'h00 || selReg == 8'h02) strb.rdKind = RK_ID;
      else if (selReg == 8'h01)               strb.rdKind = RK_VER;
      else if (inTable)                       strb.rdKind = selReg[0] ? RK_HI : RK_LO;
      else                                    strb.rdKind = RK_ZERO;
    end else strb.rdKind = RK_ZERO;
    strb.wrId = winHit && busWrite && (selReg == 8'h00);
    strb.wrLo = winHit && busWrite && inTable && !selReg[0];
    strb.wrHi = winHit && busWrite && inTable && selReg[0];
  end

  // R8: at most one target per write, and entry writes stay inside the table
  a_r8_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrId, strb.wrLo, strb.wrHi}));
  a_r8_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrLo || strb.wrHi) |-> (int'(strb.idx) < NUM_INPUTS));
endmodule

// File: rtl/irq_redir_dp.sv
module irq_redir_dp
  import irq_redir_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [SEL_W-1:0]      selReg,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic [NUM_INPUTS-1:0] pendVec,
  input  logic [NUM_INPUTS-1:0] remoteIrrSet,
  output logic [DATA_W-1:0]     busRdata,
  output logic                  svcReq,
  output logic [IDX_W-1:0]      svcIdx,
  output logic [NUM_INPUTS-1:0] entMask,
  output logic [NUM_INPUTS-1:0] entLevel,
  output logic [NUM_INPUTS-1:0] entPolarity,
  output logic [NUM_INPUTS-1:0] entRemoteIrr
);
  logic [7:0]            vecTab  [NUM_INPUTS];
  logic [2:0]            dlvTab  [NUM_INPUTS];
  logic [7:0]            destTab [NUM_INPUTS];
  logic [NUM_INPUTS-1:0] dstModeTab, dlvStatTab;
  logic [ID_W-1:0]       idReg;
  logic [IDX_W-1:0]      rdIdx;
  logic [DATA_W-1:0]     loHalf, hiHalf, rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idReg <= '0;
      for (int i = 0; i < NUM_INPUTS; i++) begin
        vecTab[i]       <= '0;
        dlvTab[i]       <= '0;
        destTab[i]      <= '0;
        dstModeTab[i]   <= 1'b0;
        dlvStatTab[i]   <= 1'b0;
        entPolarity[i]  <= 1'b0;
        entRemoteIrr[i] <= 1'b0;
        entLevel[i]     <= 1'b0;
        entMask[i]      <= 1'b1;
      end
    end else begin
      if (strb.wrId) idReg <= busWdata[27:24];
      for (int i = 0; i < NUM_INPUTS; i++) begin
        if (strb.wrLo && int'(strb.idx) == i) begin
          vecTab[i]       <= busWdata[7:0];
          dlvTab[i]       <= busWdata[10:8];
          dstModeTab[i]   <= busWdata[11];
          dlvStatTab[i]   <= busWdata[12];
          entPolarity[i]  <= busWdata[13];
          entRemoteIrr[i] <= 1'b0;
          entLevel[i]     <= busWdata[15];
          entMask[i]      <= busWdata[16];
        end else if (remoteIrrSet[i]) begin
          entRemoteIrr[i] <= 1'b1;
        end
        if (strb.wrHi && int'(strb.idx) == i) destTab[i] <= busWdata[31:24];
      end
    end
  end

  always_comb begin
    rdIdx  = (int'(strb.idx) < NUM_INPUTS) ? strb.idx : '0;
    loHalf = {15'b0, entMask[rdIdx], entLevel[rdIdx], entRemoteIrr[rdIdx],
              entPolarity[rdIdx], dlvStatTab[rdIdx], dstModeTab[rdIdx],
              dlvTab[rdIdx], vecTab[rdIdx]};
    hiHalf = {destTab[rdIdx], 24'b0};
    unique case (strb.rdKind)
      RK_SEL:  rdNext = {{(DATA_W-SEL_W){1'b0}}, selReg};
      RK_ID:   rdNext = {4'b0, idReg, 24'b0};
      RK_VER:  rdNext = {8'b0, 8'(NUM_INPUTS - 1), 8'b0, VERSION_ID};
      RK_LO:   rdNext = loHalf;
      RK_HI:   rdNext = hiHalf;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      svcReq   <= 1'b0;
      svcIdx   <= '0;
    end else begin
      busRdata <= strb.rdEn ? rdNext : '0;
      svcReq   <= (strb.wrLo || strb.wrHi) && pendVec[rdIdx];
      svcIdx   <= strb.idx;
    end
  end

  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> (busRdata == '0));
  a_r6_lo_clears_rirr: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> !entRemoteIrr[$past(rdIdx)]);
  a_r9_svc_issued: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.wrLo || strb.wrHi) && pendVec[rdIdx]) |=> (svcReq && svcIdx == $past(strb.idx)));
  a_r9_svc_cause: assert property (@(posedge clk) disable iff (!rstN)
    svcReq |-> $past(strb.wrLo || strb.wrHi));
  a_r10_mask_only_on_write: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrLo |=> $stable(entMask));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_INPUTS-1:0] pendVec,
  input  logic [NUM_INPUTS-1:0] remoteIrrSet,
  output logic                  svcReq,
  output logic [IDX_W-1:0]      svcIdx,
  output logic [NUM_INPUTS-1:0] entMask,
  output logic [NUM_INPUTS-1:0] entLevel,
  output logic [NUM_INPUTS-1:0] entPolarity,
  output logic [NUM_INPUTS-1:0] entRemoteIrr
);
  regStrobe_t       strb;
  logic [SEL_W-1:0] selReg;

  irq_redir_ctl u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .selReg(selReg), .strb(strb)
  );

  irq_redir_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .selReg(selReg), .busWdata(busWdata),
    .pendVec(pendVec), .remoteIrrSet(remoteIrrSet), .busRdata(busRdata),
    .svcReq(svcReq), .svcIdx(svcIdx), .entMask(entMask), .entLevel(entLevel),
    .entPolarity(entPolarity), .entRemoteIrr(entRemoteIrr)
  );
endmodule

// File: tb/tb_irq_redir_regs.sv
module tb_irq_redir_regs;
  localparam int N = 24;
  localparam logic [31:0] LO_KEEP = 32'h0001_BFFF;
  localparam logic [31:0] HI_KEEP = 32'hFF00_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [N-1:0] pendVec = '0, remoteIrrSet = '0;
  logic svcReq;
  logic [4:0] svcIdx;
  logic [N-1:0] entMask, entLevel, entPolarity, entRemoteIrr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mLo [N];
  logic [31:0] mHi [N];
  logic [3:0] mId;

  always #5 clk = ~clk;

  irq_redir_regs dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pendVec(pendVec),
    .remoteIrrSet(remoteIrrSet), .svcReq(svcReq), .svcIdx(svcIdx), .entMask(entMask),
    .entLevel(entLevel), .entPolarity(entPolarity), .entRemoteIrr(entRemoteIrr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWin(input logic [7:0] sel);
    if (sel == 8'h00 || sel == 8'h02) return {4'b0, mId, 24'b0};
    if (sel == 8'h01) return 32'h0017_0011;
    if (sel >= 8'h10 && sel < 8'h40) return sel[0] ? mHi[(sel - 8'h10) >> 1] : mLo[(sel - 8'h10) >> 1];
    return 32'h0;
  endfunction

  function automatic logic [N-1:0] expField(input int bitPos);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = mLo[i][bitPos];
    return v;
  endfunction

  // one bus access, then sample at the following falling edge
  task automatic access(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                        output logic [31:0] rd);
    busSel = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; remoteIrrSet = '0;
    rd = busRdata;
  endtask

  task automatic winWrite(input logic [7:0] sel, input logic [31:0] data,
                          input logic [N-1:0] pend, input logic [N-1:0] rset);
    logic [31:0] rd;
    bit isEntry;
    int n;
    access(1'b1, 8'h00, {24'b0, sel}, rd);
    isEntry = (sel >= 8'h10 && sel < 8'h40);
    n = isEntry ? int'((sel - 8'h10) >> 1) : -1;
    pendVec = pend; remoteIrrSet = rset;
    access(1'b1, 8'h10, data, rd);
    for (int i = 0; i < N; i++) if (rset[i]) mLo[i][14] = 1'b1;
    if (sel == 8'h00) mId = data[27:24];
    if (isEntry && !sel[0]) mLo[n] = data & LO_KEEP;
    if (isEntry && sel[0]) mHi[n] = data & HI_KEEP;
    check("R9 svcReq", {31'b0, svcReq}, {31'b0, isEntry && pend[n]});
    if (isEntry && pend[n]) check("R9 svcIdx", {27'b0, svcIdx}, n);
  endtask

  task automatic winRead(input logic [7:0] sel, input string req);
    logic [31:0] rd;
    access(1'b1, 8'h00, {24'b0, sel}, rd);
    access(1'b0, 8'h10, 32'h0, rd);
    check(req, rd, expWin(sel));
  endtask

  task automatic checkFields(input string tag);
    check({"R11 mask ", tag}, {8'b0, entMask}, {8'b0, expField(16)});
    check({"R11 level ", tag}, {8'b0, entLevel}, {8'b0, expField(15)});
    check({"R11 polarity ", tag}, {8'b0, entPolarity}, {8'b0, expField(13)});
    check({"R7 remote-IRR ", tag}, {8'b0, entRemoteIrr}, {8'b0, expField(14)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < N; i++) begin mLo[i] = 32'h0001_0000; mHi[i] = '0; end
    mId = '0;
    void'($urandom(32'd20417));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 rdata", busRdata, 32'h0);
    access(1'b0, 8'h00, 32'h0, rd);
    check("R10 index", rd, 32'h0);
    winRead(8'h00, "R10 id");
    winRead(8'h20, "R10 entry 8 low");
    checkFields("R10 reset");

    // R2 zero after idle cycle
    @(negedge clk);
    check("R2 idle rdata", busRdata, 32'h0);

    // R1 index register width and unused offsets
    access(1'b1, 8'h00, 32'h1234_5613, rd);
    access(1'b0, 8'h00, 32'h0, rd);
    check("R1 index readback", rd, 32'h0000_0013);
    access(1'b1, 8'h20, 32'hFFFF_FFFF, rd);
    access(1'b0, 8'h20, 32'h0, rd);
    check("R1 unused offset read", rd, 32'h0);
    access(1'b0, 8'h00, 32'h0, rd);
    check("R1 index untouched", rd, 32'h0000_0013);

    // R3 version
    winRead(8'h01, "R3 version");
    winWrite(8'h01, 32'hFFFF_FFFF, '0, '0);
    winRead(8'h01, "R3 version after write");
    winRead(8'h00, "R3 id untouched");

    // R4 identifier and its mirror
    winWrite(8'h00, 32'hA5FF_FFFF, '0, '0);
    winRead(8'h00, "R4 id");
    winRead(8'h02, "R4 mirror");
    winWrite(8'h02, 32'h0F00_0000, '0, '0);
    winRead(8'h00, "R4 id after mirror write");

    // R5 layout and R6 clearing
    winWrite(8'h16, 32'hFFFF_FFFF, '0, '0);
    winRead(8'h16, "R5 R6 entry 3 low");
    winWrite(8'h17, 32'hFFFF_FFFF, '0, '0);
    winRead(8'h17, "R5 entry 3 high");
    checkFields("R5 entry 3");

    // R7 set via strobe, kept by high write, cleared by low write
    remoteIrrSet = 24'h00_0008; @(negedge clk); remoteIrrSet = '0;
    mLo[3][14] = 1'b1;
    winRead(8'h16, "R7 set");
    winWrite(8'h17, 32'h1200_0000, '0, '0);
    winRead(8'h16, "R6 high write keeps");
    winWrite(8'h16, 32'h0000_4000, '0, '0);
    winRead(8'h16, "R6 low write clears");
    winWrite(8'h16, 32'h0000_A031, '0, 24'h00_0009);
    winRead(8'h16, "R7 write wins over set");
    winRead(8'h10, "R7 other entry set");
    checkFields("R7 mixed");

    // R8 out-of-range indices
    winWrite(8'h3E, 32'h0000_0042, '0, '0);
    winWrite(8'h40, 32'hFFFF_FFFF, 24'hFF_FFFF, '0);
    winRead(8'h40, "R8 index 0x40");
    winRead(8'h3E, "R8 entry 23 intact");
    winWrite(8'h05, 32'hFFFF_FFFF, '0, '0);
    winRead(8'h05, "R8 index 0x05");

    // R9 service request
    winWrite(8'h1E, 32'h0000_8021, 24'h00_0080, '0);
    @(negedge clk);
    check("R9 one cycle", {31'b0, svcReq}, 32'h0);
    winWrite(8'h1F, 32'h0500_0000, 24'hFF_FF7F, '0);
    winWrite(8'h1F, 32'h0600_0000, 24'h00_0080, '0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [7:0] sel;
      int pick;
      pick = $urandom_range(0, 9);
      sel = (pick == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(16, 63));
      if (pick < 6) winWrite(sel, $urandom, 24'($urandom), ($urandom_range(0, 3) == 0) ? 24'($urandom) : '0);
      else winRead(sel, "R5 random readback");
      if (it % 20 == 0) checkFields("random");
    end
    for (int i = 0; i < N; i++) begin
      winRead(8'(16 + 2 * i), "R5 final low");
      winRead(8'(17 + 2 * i), "R5 final high");
    end
    checkFields("final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule